// File: doc/BRIEF.md
# CLOCK Victim Selector with Bimodal Insertion

This block holds the replacement state of one set in a 16-way set-associative cache. It keeps one use bit per way and a clock hand that points at a way, which is 20 bits of state in total. Read hits and fills mark ways as recently used. A miss request starts a sweep that hands back the way to evict.

The sweep starts at the hand. While the way under the hand has its use bit set, the sweep clears that bit and moves the hand on by one, wrapping after the last way. The first way it finds with a clear bit is the victim, and the hand stays on that way.

A fill can set the use bit in one of three ways, chosen by the insertion mode input:
- **Normal:** always set the bit.
- **Bimodal:** set the bit only on a rare pseudo-random event, about one fill in 32.
- **Burst:** set the bit during the first half of every 128-miss window.

Write accesses leave the state untouched. Tag storage, data arrays and the choice of policy belong to the surrounding cache.

Top module: `clock_victim_sel`

## Requirements
- R1: While reset is held, and on the first cycle after it, all use bits are 0, the hand is 0, and busy and victim_valid are 0.
- R2: A read hit sets use_bits[acc_way] at the next clock edge. A read hit is acc_valid=1, acc_write=0, acc_fill=0 while busy=0.
- R3: An access with acc_write=1 changes neither use_bits nor hand, whatever the values of acc_fill and ins_mode.
- R4: On each busy cycle, if the way under the hand has its use bit set, that bit is cleared and the hand moves to (hand+1) mod 16. The first way found with a clear bit becomes the victim, and the hand stays on it. When all 16 bits are set, the sweep clears all of them and the victim is the way the hand started on.
- R5: A miss_req accepted while busy=0 raises busy at the next edge. If k consecutive set bits lie ahead of the hand, busy stays high for exactly k+1 cycles, so never more than 17. When busy drops, victim_valid pulses for one cycle with the victim on victim_way.
- R6: With ins_mode 2'b00 (normal), or the unused code 2'b11, a fill (acc_valid=1, acc_write=0, acc_fill=1) sets the use bit of acc_way.
- R7: With ins_mode 2'b01 (bimodal), a fill writes the use bit of acc_way as 1 only when the 5 low bits of a free-running 16-bit LFSR are all zero. Otherwise it writes 0, so roughly 1 fill in 32 sets the bit.
- R8: With ins_mode 2'b10 (burst), a 7-bit counter counts accepted miss requests since reset, modulo 128. A fill writes the use bit as 1 when that count is below 64 and as 0 otherwise.
- R9: While busy=1, miss_req and all accesses are ignored. No second search starts, and no use bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | Access is a write (ignored) |
| acc_fill | input | 1 | Access is a fill (else a read hit) |
| acc_way | input | 4 | Way accessed |
| ins_mode | input | 2 | Fill insertion mode: 00 normal, 01 bimodal, 10 burst, 11 normal |
| miss_req | input | 1 | Start a victim search |
| busy | output | 1 | Search in progress |
| victim_valid | output | 1 | One-cycle strobe: victim_way is valid |
| victim_way | output | 4 | Selected victim |
| use_bits | output | 16 | Current use bit of each way |
| hand | output | 4 | Current clock hand |

## Verification
The assertions check on every cycle that:
- each sweep step clears the bit under the hand and advances the hand by one;
- a victim always has a clear bit and has the hand parked on it;
- no search lasts longer than 17 cycles;
- writes leave the state unchanged, and hits and normal fills set their bit;
- accesses made during a search set nothing.

The statistical rate of bimodal insertion, the 64-on/64-off schedule of burst mode across the miss count, and the exact k+1 latency for each use-bit pattern can only be shown by the bench's scenarios. The bench checks that latency against a model of the bits over hundreds of patterns, including the case where every bit is set.

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int          WAYS      = 16,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter int          RAND_BITS = 5,
  parameter int          BURST_W   = 7,
  localparam int         HAND_W    = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_fill,
  input  logic [HAND_W-1:0] acc_way,
  input  logic [1:0]        ins_mode,
  input  logic              miss_req,
  output logic              busy,
  output logic              victim_valid,
  output logic [HAND_W-1:0] victim_way,
  output logic [WAYS-1:0]   use_bits,
  output logic [HAND_W-1:0] hand
);

  logic [WAYS-1:0]   use_q;
  logic [HAND_W-1:0] hand_q, vict_q;
  logic              busy_q, vv_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic [BURST_W-1:0] miss_cnt;
  logic              ins_bit;

  wire acc_en   = acc_valid && !acc_write && !busy_q;
  wire start    = miss_req && !busy_q;
  wire cur_set  = use_q[hand_q];
  wire rnd_hit  = lfsr_q[RAND_BITS-1:0] == '0;
  wire burst_on = !miss_cnt[BURST_W-1];
  wire fb       = ^(lfsr_q & LFSR_TAPS[LFSR_W-1:0]);
  wire [HAND_W-1:0] hand_nxt = (hand_q == HAND_W'(WAYS-1)) ? '0 : hand_q + 1'b1;

  always_comb begin
    case (ins_mode)
      2'b01:   ins_bit = rnd_hit;
      2'b10:   ins_bit = burst_on;
      default: ins_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      use_q    <= '0;
      hand_q   <= '0;
      vict_q   <= '0;
      busy_q   <= 1'b0;
      vv_q     <= 1'b0;
      lfsr_q   <= LFSR_SEED[LFSR_W-1:0];
      miss_cnt <= '0;
    end else begin
      lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
      vv_q   <= 1'b0;
      if (start) begin
        busy_q   <= 1'b1;
        miss_cnt <= miss_cnt + 1'b1;
      end
      if (busy_q) begin
        if (cur_set) begin
          use_q[hand_q] <= 1'b0;
          hand_q        <= hand_nxt;
        end else begin
          busy_q <= 1'b0;
          vv_q   <= 1'b1;
          vict_q <= hand_q;
        end
      end
      if (acc_en)
        use_q[acc_way] <= acc_fill ? ins_bit : 1'b1;
    end
  end

  assign busy         = busy_q;
  assign victim_valid = vv_q;
  assign victim_way   = vict_q;
  assign use_bits     = use_q;
  assign hand         = hand_q;

endmodule

module clock_victim_sel_chk #(
  parameter int  WAYS   = 16,
  localparam int HAND_W = $clog2(WAYS),
  localparam int CNT_W  = $clog2(WAYS + 2) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              acc_fill,
  input logic [HAND_W-1:0] acc_way,
  input logic [1:0]        ins_mode,
  input logic              miss_req,
  input logic              busy,
  input logic              victim_valid,
  input logic [HAND_W-1:0] victim_way,
  input logic [WAYS-1:0]   use_bits,
  input logic [HAND_W-1:0] hand
);

  logic [CNT_W-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cnt <= '0;
    else                 busy_cnt <= busy_cnt + 1'b1;
  end

  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt <= CNT_W'(WAYS));

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> !victim_valid);

  assert_victim_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> (!use_bits[victim_way] && hand == victim_way && !busy));

  assert_sweep_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && use_bits[hand]) |=>
      (!use_bits[$past(hand)] &&
       hand == (($past(hand) == HAND_W'(WAYS-1)) ? '0 : HAND_W'($past(hand) + 1'b1))));

  assert_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !busy) |=> ($stable(use_bits) && $stable(hand)));

  assert_hit_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !acc_fill && !busy) |=> use_bits[$past(acc_way)]);

  assert_normal_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_fill && !busy && (ins_mode == 2'b00 || ins_mode == 2'b11))
      |=> use_bits[$past(acc_way)]);

  assert_busy_access_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_valid && !use_bits[acc_way]) |=> !use_bits[$past(acc_way)]);

endmodule

bind clock_victim_sel clock_victim_sel_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_fill(acc_fill), .acc_way(acc_way), .ins_mode(ins_mode), .miss_req(miss_req),
  .busy(busy), .victim_valid(victim_valid), .victim_way(victim_way),
  .use_bits(use_bits), .hand(hand)
);

// File: tb/test_clock_victim_sel.sv
`timescale 1ns/1ps
module test_clock_victim_sel;
  logic       clk = 0, rst_n = 0;
  logic       acc_valid = 0, acc_write = 0, acc_fill = 0, miss_req = 0;
  logic [3:0] acc_way = 0;
  logic [1:0] ins_mode = 0;
  logic       busy, victim_valid;
  logic [3:0] victim_way, hand;
  logic [15:0] use_bits;

  clock_victim_sel i_clock_victim_sel (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] m_use = 0;
  int m_hand = 0, misses = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R5 watchdog: actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check_state(string req);
    check(use_bits == m_use, req, "use_bits", use_bits, m_use);
    check(hand == 4'(m_hand), req, "hand", hand, m_hand);
  endtask

  task automatic do_access(bit wr, bit fl, int way, logic [1:0] mode, string req);
    acc_valid = 1; acc_write = wr; acc_fill = fl; acc_way = 4'(way); ins_mode = mode;
    tick();
    acc_valid = 0; acc_write = 0; acc_fill = 0;
    if (!wr) begin
      if (!fl) m_use[way] = 1'b1;
      else case (mode)
        2'b01: m_use[way] = use_bits[way];
        2'b10: m_use[way] = (misses % 128) < 64;
        default: m_use[way] = 1'b1;
      endcase
    end
    check_state(req);
  endtask

  task automatic expect_search(output int k, output int p);
    k = 0; p = m_hand;
    while (k < 16 && m_use[p]) begin
      m_use[p] = 1'b0; k++; p = (p + 1) % 16;
    end
  endtask

  task automatic do_miss(string req);
    int k, p, c;
    expect_search(k, p);
    miss_req = 1; tick(); miss_req = 0;
    check(busy == 1, "R5", "busy after miss_req", busy, 1);
    c = 0;
    while (!victim_valid && c < 40) begin tick(); c++; end
    m_hand = p; misses++;
    check(c == k + 1, req, "search cycles", c, k + 1);
    check(victim_way == 4'(p), req, "victim_way", victim_way, p);
    check(busy == 0, "R5", "busy at victim strobe", busy, 0);
    check_state(req);
  endtask

  initial begin
    int ones;
    tick(); tick();
    check(use_bits == 0 && hand == 0, "R1", "state in reset", use_bits, 0);
    check(busy == 0 && victim_valid == 0, "R1", "flags in reset", busy, 0);
    rst_n = 1; tick();
    check_state("R1");
    check(busy == 0 && victim_valid == 0, "R1", "flags after reset", victim_valid, 0);

    for (int w = 0; w < 16; w += 2) do_access(0, 0, w, 2'b00, "R2");
    for (int w = 0; w < 16; w++) do_access(1, w[0], w, 2'(w), "R3");
    for (int w = 1; w < 16; w += 2) do_access(0, 0, w, 2'b00, "R2");
    do_miss("R4");

    for (int r = 0; r < 300; r++) begin
      logic [15:0] mask;
      mask = 16'($urandom);
      if (r % 37 == 5) mask = 16'hFFFF;
      if (r % 41 == 7) mask = 16'h0000;
      for (int w = 0; w < 16; w++) if (mask[w]) do_access(0, 0, w, 2'b00, "R2");
      do_miss("R4");
      do_access(0, 1, m_hand, (r % 2) ? 2'b11 : 2'b00, "R6");
      if (r % 50 == 3) do_access(1, 0, (r + 4) % 16, 2'b00, "R3");
    end

    for (int r = 0; r < 200; r++) begin
      do_miss("R5");
      do_access(0, 1, m_hand, 2'b10, "R8");
    end

    ones = 0;
    for (int r = 0; r < 2048; r++) begin
      do_access(0, 1, 3, 2'b01, "R7");
      if (use_bits[3]) ones++;
    end
    check(ones >= 32 && ones <= 96, "R7", "bimodal set count of 2048", ones, 64);

    begin
      int k, p, c;
      for (int i = 0; i < 4; i++) do_access(0, 0, (m_hand + i) % 16, 2'b00, "R2");
      expect_search(k, p);
      miss_req = 1; tick();
      acc_valid = 1; acc_write = 0; acc_fill = 0; acc_way = 4'(p);
      tick(); c = 1;
      acc_valid = 0; miss_req = 0;
      while (!victim_valid && c < 40) begin tick(); c++; end
      m_hand = p; misses++;
      check(c == k + 1, "R9", "search cycles with busy inputs", c, k + 1);
      check(victim_way == 4'(p), "R9", "victim_way", victim_way, p);
      check(use_bits[p] == 0, "R9", "hit during busy ignored", use_bits[p], 0);
      check_state("R9");
      for (int i = 0; i < 4; i++) begin
        tick();
        check(busy == 0 && victim_valid == 0, "R9", "no second search", busy, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule